// File: doc/BRIEF.md
# Selectable-Rate Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes. The line rests high. Each frame has a low start bit, eight data bits sent least significant bit first, no parity bit, and one high stop bit. The block runs from a 14.7456 MHz reference clock. It derives a sampling tick at sixteen times the bit rate by dividing that clock by a ratio chosen with a 3-bit rate code. The codes cover the usual rates from 115200 baud down to 1200 baud.

The input line first passes through a two-flop synchronizer. A falling edge seen while idle restarts the tick divider, so the sampling phase is tied to the frame. The start bit is confirmed halfway through the bit. Each data bit and the stop bit is then sampled at the centre of its bit period. A good frame produces the byte and a one-cycle valid pulse. A low stop bit produces a one-cycle framing-error pulse instead. If the line is already low while the receiver sits in its stop phase, the receiver starts the next frame at once, so frames may follow each other with no idle time between them.

Top module: `uart_rx_selbaud`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rx_data` is 0x00 and `rx_valid` and `rx_frame_err` are both 0.
- R2: Rate codes map to clock-per-tick ratios as follows: 0→8, 1→16, 2→24, 3→48, 4→96, 5→192, 6→384, 7→768. One bit lasts 16 ticks.
- R3: A frame begins only on a high-to-low change of the idle-high line. If the line is back high at the start bit's midpoint (8 ticks in), the receiver drops the attempt without any output.
- R4: Data bits are taken in arrival order into `rx_data` bit 0 through bit 7, so the first data bit becomes bit 0.
- R5: Let cycle t be the first rising clock edge at which `rx_i` is low for a frame. `rx_valid` is then high for exactly the one cycle that follows edge t+2+152·ratio.
- R6: A stop bit sampled low raises `rx_frame_err` for one cycle, at the same point at which `rx_valid` would have risen. In that case there is no valid pulse and `rx_data` is unchanged. The receiver then waits for the line to go high before it accepts a new start edge.
- R7: A low line during the stop phase, that is, after a good stop sample, starts the next frame with the same latency as R5. This holds even when the next start bit directly follows the stop bit.
- R8: The rate code is captured only while idle. A change during a frame does not alter that frame's timing.
- R9: `rx_data` changes only in a cycle in which `rx_valid` is high, and `rx_valid` and `rx_frame_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 14.7456 MHz reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| rate_sel | input | 3 | Rate code (see R2) |
| rx_data | output | 8 | Last correctly received byte |
| rx_valid | output | 1 | One-cycle pulse when a good byte arrives |
| rx_frame_err | output | 1 | One-cycle pulse when a stop bit is low |

## Verification
Frames with no gap between them are the sharpest case. In that case the end of the stop phase and the next start bit fall on the same clock edge. A receiver that gave the return to idle priority would lose the second byte entirely. Short low glitches, up to just under half a bit, must produce nothing. A receiver that trusted the edge alone would emit a spurious byte. A frame with a low stop bit, including one followed by a long low break, must raise only the error pulse and keep the old byte. A receiver that resynchronised on the break would report ghost frames. A rate-code change in the middle of a frame must leave the strobe cycle exactly where it was, or the byte arrives late and garbled.

// File: rtl/uart_rx_selbaud_pkg.sv
// Package: shared widths, the receiver state type and the rate-code to
// divide-ratio function. Assumes a 14.7456 MHz reference clock, for which
// the smallest ratio yields sixteen ticks per bit at 115200 baud.
package uart_rx_selbaud_pkg;

    localparam int RATE_W   = 3;
    localparam int BASE_DIV = 8;
    localparam int MAX_DIV  = 3 * BASE_DIV * (1 << ((1 << RATE_W) - 3));
    localparam int RATIO_W  = $clog2(MAX_DIV + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_RECOVER
    } rx_state_t;

    // Clocks per oversample tick for a rate code: 8, 16, then 24 doubling.
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [RATE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        if (code == '0) begin
            r = RATIO_W'(BASE_DIV);
        end else if (code == RATE_W'(1)) begin
            r = RATIO_W'(2 * BASE_DIV);
        end else begin
            r = RATIO_W'(3 * BASE_DIV) << (code - RATE_W'(2));
        end
        return r;
    endfunction

endpackage

// File: rtl/uart_rx_selbaud_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes the input may change at any time; the flops reset to the line's
// idle level so that no edge appears when reset is released.
module uart_rx_selbaud_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Purpose: shift the async level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_selbaud_tick.sv
// Oversample tick generator. It divides the reference clock by the ratio
// picked with the rate code. The ratio is captured only while load_en is
// high (receiver idle). restart clears the phase so the first tick comes
// exactly one ratio after the restart edge.
module uart_rx_selbaud_tick
    import uart_rx_selbaud_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATE_W-1:0]  rate_sel,
    input  logic               load_en,
    input  logic               restart,
    output logic               tick,
    output logic [RATIO_W-1:0] ratio_cur
);

    logic [RATIO_W-1:0] ratio_q;
    logic [RATIO_W-1:0] cnt_q;

    // Purpose: hold the active divide ratio, refreshed only when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= ratio_of('0);
        end else if (load_en) begin
            ratio_q <= ratio_of(rate_sel);
        end
    end

    // Purpose: count reference clocks within one tick period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + RATIO_W'(1);
        end
    end

    assign tick      = (cnt_q == ratio_q - RATIO_W'(1));
    assign ratio_cur = ratio_q;

endmodule

// File: rtl/uart_rx_selbaud_fsm.sv
// Frame sequencer: it detects the start edge, confirms the start bit at
// its midpoint, samples the data bits and the stop bit at their centres,
// and issues the byte with a valid or framing-error pulse. It assumes a
// synchronized line and one tick per 1/OVERSAMPLE of a bit.
module uart_rx_selbaud_fsm
    import uart_rx_selbaud_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_s,
    input  logic                 tick,
    output logic                 restart,
    output logic                 idle,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 ferr_o
);

    localparam int OS_W  = $clog2(OVERSAMPLE);
    localparam int BI_W  = $clog2(DATA_BITS + 1);
    localparam logic [OS_W-1:0] OS_LAST = OS_W'(OVERSAMPLE - 1);
    localparam logic [OS_W-1:0] OS_MID  = OS_W'(OVERSAMPLE / 2 - 1);

    rx_state_t            state_q;
    logic                 line_prev_q;
    logic [OS_W-1:0]      os_q;
    logic [BI_W-1:0]      bit_q;
    logic [DATA_BITS-1:0] shift_q;
    logic                 fall;

    assign fall    = line_prev_q && !line_s;
    assign restart = ((state_q == ST_IDLE) && fall) ||
                     ((state_q == ST_STOP) && !line_s);
    assign idle    = (state_q == ST_IDLE);

    // Purpose: remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_prev_q <= 1'b1;
        end else begin
            line_prev_q <= line_s;
        end
    end

    // Purpose: frame state, tick counting, bit capture and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            os_q    <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (fall) begin
                        state_q <= ST_START;
                        os_q    <= '0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (os_q == OS_MID) begin
                            os_q    <= '0;
                            bit_q   <= '0;
                            state_q <= line_s ? ST_IDLE : ST_DATA;
                        end else begin
                            os_q <= os_q + OS_W'(1);
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (os_q == OS_LAST) begin
                            os_q <= '0;
                            if (bit_q < BI_W'(DATA_BITS)) begin
                                shift_q <= {line_s, shift_q[DATA_BITS-1:1]};
                                bit_q   <= bit_q + BI_W'(1);
                            end else if (line_s) begin
                                data_o  <= shift_q;
                                valid_o <= 1'b1;
                                state_q <= ST_STOP;
                            end else begin
                                ferr_o  <= 1'b1;
                                state_q <= ST_RECOVER;
                            end
                        end else begin
                            os_q <= os_q + OS_W'(1);
                        end
                    end
                end
                ST_STOP: begin
                    if (!line_s) begin
                        state_q <= ST_START;
                        os_q    <= '0;
                    end else if (tick) begin
                        if (os_q == OS_MID) begin
                            state_q <= ST_IDLE;
                        end else begin
                            os_q <= os_q + OS_W'(1);
                        end
                    end
                end
                ST_RECOVER: begin
                    if (line_s) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_selbaud.sv
// Top level: synchronizer, tick generator and frame sequencer.
// Assumes a 14.7456 MHz clock and an idle-high line carrying frames of
// one start bit, DATA_BITS data bits (no parity) and one stop bit.
module uart_rx_selbaud
    import uart_rx_selbaud_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_i,
    input  logic [RATE_W-1:0]    rate_sel,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_frame_err
);

    logic               line_s;
    logic               tick;
    logic               restart;
    logic               fsm_idle;
    logic [RATIO_W-1:0] cur_ratio;

    uart_rx_selbaud_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_i),
        .q_sync  (line_s)
    );

    uart_rx_selbaud_tick u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .load_en   (fsm_idle),
        .restart   (restart),
        .tick      (tick),
        .ratio_cur (cur_ratio)
    );

    uart_rx_selbaud_fsm #(
        .DATA_BITS  (DATA_BITS),
        .OVERSAMPLE (OVERSAMPLE)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_s  (line_s),
        .tick    (tick),
        .restart (restart),
        .idle    (fsm_idle),
        .data_o  (rx_data),
        .valid_o (rx_valid),
        .ferr_o  (rx_frame_err)
    );

endmodule

// File: rtl/uart_rx_selbaud_chk.sv
// Checker for uart_rx_selbaud, attached with bind below. It watches the
// output pulses, the byte register and the captured divide ratio.
module uart_rx_selbaud_chk
    import uart_rx_selbaud_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_valid,
    input logic                 rx_frame_err,
    input logic [RATIO_W-1:0]   cur_ratio,
    input logic                 fsm_idle
);

    // R9: the two result pulses are exclusive
    a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_frame_err));

    // R5: a valid pulse lasts one cycle
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6: an error pulse lasts one cycle
    a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |=> !rx_frame_err);

    // R9: the byte moves only together with a valid pulse
    a_r9_data_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_valid);

    // R8: the active ratio changes only after an idle cycle
    a_r8_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_ratio) |-> $past(fsm_idle));

    // R2: the active ratio is one of the eight table entries
    a_r2_ratio_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ratio == RATIO_W'(8))   || (cur_ratio == RATIO_W'(16))  ||
        (cur_ratio == RATIO_W'(24))  || (cur_ratio == RATIO_W'(48))  ||
        (cur_ratio == RATIO_W'(96))  || (cur_ratio == RATIO_W'(192)) ||
        (cur_ratio == RATIO_W'(384)) || (cur_ratio == RATIO_W'(768)));

endmodule

bind uart_rx_selbaud uart_rx_selbaud_chk #(
    .DATA_BITS (DATA_BITS)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err),
    .cur_ratio    (cur_ratio),
    .fsm_idle     (fsm_idle)
);

// File: tb/test_uart_rx_selbaud.sv
// Bench: drives serial frames and keeps a queue of expected result
// events, computed from the timing rule. Outputs are compared every clock.
module test_uart_rx_selbaud;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [2:0] rate = 3'd0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_frame_err;

    int         cyc = 0;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;
    string      cur_req = "R1";
    logic [7:0] last_good = 8'h00;

    int         q_at[$];
    logic [7:0] q_d[$];
    bit         q_err[$];

    uart_rx_selbaud i_uart_rx_selbaud (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_i         (rx),
        .rate_sel     (rate),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Ratio table from R2
    function automatic int exp_ratio(input logic [2:0] code);
        case (code)
            3'd0: return 8;
            3'd1: return 16;
            3'd2: return 24;
            3'd3: return 48;
            3'd4: return 96;
            3'd5: return 192;
            3'd6: return 384;
            default: return 768;
        endcase
    endfunction

    task automatic report;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends one frame at ratio r, queueing the expected result (R5/R6).
    task automatic send_frame(input logic [7:0] d, input bit stop_hi, input int r);
        int t;
        rx = 1'b0;
        t = cyc + 1;
        q_at.push_back(t + 2 + 152 * r);
        q_d.push_back(d);
        q_err.push_back(!stop_hi);
        wait_n(16 * r);
        for (int i = 0; i < 8; i++) begin
            rx = d[i];
            wait_n(16 * r);
        end
        rx = stop_hi;
        wait_n(16 * r);
    endtask

    // Per-clock comparison against the expected event queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic       ev_v;
            logic       ev_e;
            logic [7:0] ev_d;
            ev_v = 1'b0;
            ev_e = 1'b0;
            ev_d = last_good;
            if (q_at.size() > 0 && q_at[0] == cyc) begin
                ev_e = q_err[0];
                ev_v = !q_err[0];
                if (!q_err[0]) ev_d = q_d[0];
                void'(q_at.pop_front());
                void'(q_d.pop_front());
                void'(q_err.pop_front());
            end
            total++;
            if (rx_valid !== ev_v || rx_frame_err !== ev_e || rx_data !== ev_d) begin
                bad++;
                $display("FAIL %s cycle %0d: valid=%0b err=%0b data=%02h expected valid=%0b err=%0b data=%02h",
                         cur_req, cyc, rx_valid, rx_frame_err, rx_data, ev_v, ev_e, ev_d);
            end
            last_good = ev_d;
        end
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run exceeded %0d cycles, expected completion", WATCHDOG);
            report();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_n(5);
        total++;
        if (rx_data !== 8'h00 || rx_valid !== 1'b0 || rx_frame_err !== 1'b0) begin
            bad++;
            $display("FAIL R1 in reset: data=%02h valid=%0b err=%0b expected 00 0 0",
                     rx_data, rx_valid, rx_frame_err);
        end
        rst_n = 1'b1;
        wait_n(20);

        // R4 / R5: several byte patterns at code 0
        cur_req = "R4";
        send_frame(8'h00, 1'b1, 8); wait_n(40);
        send_frame(8'hFF, 1'b1, 8); wait_n(40);
        send_frame(8'h55, 1'b1, 8); wait_n(40);
        cur_req = "R5";
        send_frame(8'hAA, 1'b1, 8); wait_n(40);
        send_frame(8'h01, 1'b1, 8); wait_n(40);
        send_frame(8'h80, 1'b1, 8); wait_n(200);

        // R3: short low glitches, the longest just under half a bit
        cur_req = "R3";
        rx = 1'b0; wait_n(4 * 8);  rx = 1'b1; wait_n(300);
        rx = 1'b0; wait_n(7 * 8);  rx = 1'b1; wait_n(300);
        send_frame(8'h3C, 1'b1, 8); wait_n(200);

        // R6: low stop bit, then recovery; also a long break
        cur_req = "R6";
        send_frame(8'hC3, 1'b0, 8); rx = 1'b1; wait_n(300);
        send_frame(8'h5A, 1'b1, 8); wait_n(200);
        send_frame(8'h96, 1'b0, 8); wait_n(40 * 8); rx = 1'b1; wait_n(300);
        send_frame(8'h69, 1'b1, 8); wait_n(200);

        // R7: frames with no gap, then a short gap
        cur_req = "R7";
        send_frame(8'h11, 1'b1, 8);
        send_frame(8'hEE, 1'b1, 8);
        send_frame(8'h80, 1'b1, 8);
        rx = 1'b1; wait_n(5);
        send_frame(8'h7E, 1'b1, 8); wait_n(300);

        // R2: other rate codes
        cur_req = "R2";
        rate = 3'd1; wait_n(20);
        send_frame(8'hB4, 1'b1, exp_ratio(3'd1)); wait_n(400);
        rate = 3'd2; wait_n(20);
        send_frame(8'h2D, 1'b1, exp_ratio(3'd2)); wait_n(600);
        rate = 3'd3; wait_n(20);
        send_frame(8'hD2, 1'b1, exp_ratio(3'd3)); wait_n(1200);

        // R8: a rate change in mid-frame has no effect on that frame
        cur_req = "R8";
        rate = 3'd0; wait_n(20);
        fork
            send_frame(8'h47, 1'b1, 8);
            begin
                wait_n(300);
                rate = 3'd5;
            end
        join
        rate = 3'd0; wait_n(300);
        send_frame(8'h9B, 1'b1, 8); wait_n(300);

        // R9 covered by the per-clock comparison; drain and finish
        cur_req = "R9";
        wait_n(50);
        total++;
        if (q_at.size() != 0) begin
            bad++;
            $display("FAIL R5 pending events: actual=%0d expected=0", q_at.size());
        end
        done = 1'b1;
        report();
        $finish;
    end

endmodule